// File: doc/BRIEF.md
# Indexed Configuration Window

This block is a byte-wide register window for a peripheral controller, reached through two adjacent I/O addresses. A write to the lower address stores an 8-bit selector. Reads and writes at the data address then reach the register that the selector picks, out of 256.

Data writes go through a per-selector policy. Most selectors are locked and ignore writes. Two selectors take exactly one fixed byte and keep their value for any other byte. The rest take any byte. A number of registers have non-zero values after reset.

A separate enable input opens the whole window. The host drives it from bit 1 of its own configuration byte at offset 0x85. While the enable is low, the window ignores every access.

Top module: `cfgwin_top`

## Requirements
- R1: After reset the selector is 0x00 and rdata_o is 0x00.
- R2: With the default base 0x03F0, a write to 0x03F0 loads the selector from wdata_i, and a write to 0x03F1 is a data write. Any address other than these two is ignored. A read at an address outside the window returns 0xFF.
- R3: A data write is ignored when the selector is in 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB or 0xFD–0xFF. These registers read back their reset value, which is 0x00.
- R4: Register 0xE7 changes only on a write of 0xFE, and register 0xE8 changes only on a write of 0xBE. Any other byte leaves either register as it was.
- R5: Selectors 0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 and 0xFC store any byte written to them.
- R6: A read at either window address with the enable high returns the selected register on rdata_o in the cycle after rd_en_i. rdata_o holds its value between reads.
- R7: While win_en_i is low, reads return 0xFF, data writes change nothing, and selector writes leave the selector unchanged.
- R8: Reset loads 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE and 0xE8=0xBE. Every other register resets to 0x00.
- R9: When a read and a data write hit the window in the same cycle, the read returns the value the register had before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | I/O byte address |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| rd_en_i | input | 1 | Read strobe, one cycle per access |
| wdata_i | input | 8 | Write byte |
| win_en_i | input | 1 | Window enable |
| rdata_o | output | 8 | Read byte, valid the cycle after rd_en_i |

## Verification
The bench writes a selector-dependent byte to every one of the 256 selectors and reads each one back. This shows locked, keyed and open registers apart, because the byte never matches a key. Writes of the matching key byte and of a wrong byte to the two keyed registers test the compare itself. Accesses with the enable low, and accesses just outside the two-address window, show that the enable and the decode each block the access on their own. A read and a write in the same cycle show whether the read returns the value from before the write. A behavioural model tracks the selector and all registers and is compared with rdata_o on every cycle.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  localparam int IDX_W = 8;
  localparam int DAT_W = 8;

  typedef enum logic [1:0] {
    POL_LOCKED,
    POL_OPEN,
    POL_KEYED
  } wr_pol_e;

  function automatic wr_pol_e pol_of(input logic [IDX_W-1:0] sel);
    if (sel < 8'hE0) return POL_LOCKED;
    case (sel)
      8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE6,
      8'hEE, 8'hEF, 8'hF0, 8'hF1, 8'hF2,
      8'hF4, 8'hF6, 8'hF8, 8'hFC: return POL_OPEN;
      8'hE7, 8'hE8:               return POL_KEYED;
      default:                    return POL_LOCKED;
    endcase
  endfunction

  function automatic logic [DAT_W-1:0] key_of(input logic [IDX_W-1:0] sel);
    case (sel)
      8'hE7:   return 8'hFE;
      8'hE8:   return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [DAT_W-1:0] init_of(input logic [IDX_W-1:0] sel);
    case (sel)
      8'hE0:   return 8'h3C;
      8'hE2:   return 8'h03;
      8'hE3:   return 8'hFC;
      8'hE6:   return 8'hDE;
      8'hE7:   return 8'hFE;
      8'hE8:   return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfgwin_decode.sv
module cfgwin_decode #(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              win_en_i,
  output logic              idx_we_o,
  output logic              dat_we_o,
  output logic              rd_hit_o
);
  logic in_win;
  logic at_idx;

  assign in_win   = (addr_i[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);
  assign at_idx   = (addr_i[0] == BASE_ADDR[0]);
  assign idx_we_o = wr_en_i && win_en_i && in_win && at_idx;
  assign dat_we_o = wr_en_i && win_en_i && in_win && !at_idx;
  assign rd_hit_o = rd_en_i && win_en_i && in_win;
endmodule

// File: rtl/cfgwin_filter.sv
module cfgwin_filter
  import cfgwin_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DAT_W-1:0] wdata_i,
  input  logic             dat_we_i,
  output logic             commit_o
);
  wr_pol_e pol;

  always_comb begin
    pol = pol_of(idx_i);
    unique case (pol)
      POL_OPEN:  commit_o = dat_we_i;
      POL_KEYED: commit_o = dat_we_i && (wdata_i == key_of(idx_i));
      default:   commit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfgwin_regs.sv
module cfgwin_regs
  import cfgwin_pkg::*;
#(
  parameter logic [IDX_W-1:0] LO_IDX = 8'hE0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DAT_W-1:0] wdata_i,
  output logic [DAT_W-1:0] rd_val_o
);
  localparam int NUM   = (1 << IDX_W) - int'(LO_IDX);
  localparam int SEL_W = (NUM > 1) ? $clog2(NUM) : 1;

  // only the upper band holds state; everything below reads zero
  logic [DAT_W-1:0] q [NUM];
  logic [IDX_W-1:0] off;

  for (genvar i = 0; i < NUM; i++) begin : g_reg
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(int'(LO_IDX) + i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          q[i] <= init_of(MY_IDX);
      else if (commit_i && idx_i == MY_IDX) q[i] <= wdata_i;
    end

    if (pol_of(MY_IDX) == POL_KEYED) begin : g_key
      p_key_value_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q[i] == key_of(MY_IDX));
    end
  end

  assign off      = idx_i - LO_IDX;
  assign rd_val_o = (idx_i >= LO_IDX) ? q[off[SEL_W-1:0]] : '0;
endmodule

// File: rtl/cfgwin_top.sv
module cfgwin_top
  import cfgwin_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
  parameter logic [IDX_W-1:0]  LO_IDX    = 8'hE0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DAT_W-1:0]  wdata_i,
  input  logic              win_en_i,
  output logic [DAT_W-1:0]  rdata_o
);
  logic             idx_we, dat_we, rd_hit, commit;
  logic [IDX_W-1:0] idx_q;
  logic [DAT_W-1:0] rd_val;
  logic [DAT_W-1:0] rdata_q;

  cfgwin_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) i_decode (
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .win_en_i (win_en_i),
    .idx_we_o (idx_we),
    .dat_we_o (dat_we),
    .rd_hit_o (rd_hit)
  );

  cfgwin_filter i_filter (
    .idx_i    (idx_q),
    .wdata_i  (wdata_i),
    .dat_we_i (dat_we),
    .commit_o (commit)
  );

  cfgwin_regs #(.LO_IDX(LO_IDX)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .idx_i    (idx_q),
    .wdata_i  (wdata_i),
    .rd_val_o (rd_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (idx_we) idx_q <= wdata_i;
  end

  // read samples pre-write state, so a same-cycle write is not seen
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_hit ? rd_val : '1;
  end

  assign rdata_o = rdata_q;

  p_one_port_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({idx_we, dat_we}));

  p_idx_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_we |=> idx_q == $past(wdata_i));

  p_off_rd_ff_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !win_en_i) |=> rdata_o == 8'hFF);

  p_off_idx_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_en_i |=> $stable(idx_q));

  p_locked_no_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q < LO_IDX) |-> !commit);

  p_rd_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/test_cfgwin_top.sv
`timescale 1ns/1ps
module test_cfgwin_top;
  localparam logic [15:0] BASE = 16'h03F0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, win_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfgwin_top i_cfgwin_top (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .wdata_i(wdata), .win_en_i(win_en), .rdata_o(rdata)
  );

  // ---- behavioural reference ----
  function automatic bit m_open(int s);
    return (s inside {[8'hE0:8'hE3], 8'hE6, [8'hEE:8'hF2], 8'hF4, 8'hF6, 8'hF8, 8'hFC});
  endfunction

  function automatic int m_init(int s);
    case (s)
      8'hE0: return 8'h3C; 8'hE2: return 8'h03; 8'hE3: return 8'hFC;
      8'hE6: return 8'hDE; 8'hE7: return 8'hFE; 8'hE8: return 8'hBE;
      default: return 0;
    endcase
  endfunction

  int m_reg [256];
  int m_idx;
  int m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 256; k++) m_reg[k] = m_init(k);
      m_idx = 0;
      m_rd  = 0;
    end else begin
      bit hit;
      hit = (addr == BASE) || (addr == BASE + 16'd1);
      if (rd_en) m_rd = (hit && win_en) ? m_reg[m_idx] : 8'hFF;
      if (wr_en && hit && win_en) begin
        if (addr == BASE) m_idx = wdata;
        else if (m_open(m_idx) ||
                 (m_idx == 8'hE7 && wdata == 8'hFE) ||
                 (m_idx == 8'hE8 && wdata == 8'hBE))
          m_reg[m_idx] = wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (int'(rdata) != m_rd) begin
        errors++;
        $display("FAIL R6 model: rdata=%02h expected=%02h", rdata, m_rd[7:0]);
      end
    end
  end

  // ---- stimulus ----
  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [15:0] a);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic sel_rd(logic [7:0] s);
    wr(BASE, s);
    rd(BASE + 16'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata after reset", rdata, 8'h00);

    win_en = 1'b1;
    rd(BASE + 16'd1);
    chk("R1 selector resets to 0", rdata, 8'h00);

    sel_rd(8'hE0); chk("R8 default E0", rdata, 8'h3C);
    sel_rd(8'hE1); chk("R8 default E1", rdata, 8'h00);
    sel_rd(8'hE2); chk("R8 default E2", rdata, 8'h03);
    sel_rd(8'hE3); chk("R8 default E3", rdata, 8'hFC);
    sel_rd(8'hE6); chk("R8 default E6", rdata, 8'hDE);
    sel_rd(8'hE7); chk("R8 default E7", rdata, 8'hFE);
    sel_rd(8'hE8); chk("R8 default E8", rdata, 8'hBE);

    // R6: both window addresses read the selected register
    wr(BASE, 8'hE6);
    rd(BASE); chk("R6 read at index address", rdata, 8'hDE);
    rd(BASE + 16'd1); chk("R6 read at data address", rdata, 8'hDE);

    // R2: neighbours of the window are not decoded
    wr(BASE + 16'd2, 8'h11);
    wr(BASE - 16'd1, 8'h22);
    rd(BASE + 16'd1); chk("R2 outside writes ignored", rdata, 8'hDE);
    rd(BASE + 16'd2); chk("R2 outside read FF", rdata, 8'hFF);
    rd(16'h13F0);     chk("R2 upper address bits decoded", rdata, 8'hFF);

    // R7: disabled window
    wr(BASE, 8'hE1); wr(BASE + 16'd1, 8'h77);
    win_en = 1'b0;
    rd(BASE + 16'd1); chk("R7 disabled read FF", rdata, 8'hFF);
    wr(BASE + 16'd1, 8'h99);
    wr(BASE, 8'hE0);
    win_en = 1'b1;
    rd(BASE + 16'd1); chk("R7 selector and data kept", rdata, 8'h77);

    // R4: keyed registers
    wr(BASE, 8'hE7); wr(BASE + 16'd1, 8'h00);
    rd(BASE + 16'd1); chk("R4 E7 wrong byte", rdata, 8'hFE);
    wr(BASE + 16'd1, 8'hFE);
    rd(BASE + 16'd1); chk("R4 E7 key byte", rdata, 8'hFE);
    wr(BASE, 8'hE8); wr(BASE + 16'd1, 8'hFE);
    rd(BASE + 16'd1); chk("R4 E8 wrong byte", rdata, 8'hBE);
    wr(BASE + 16'd1, 8'hBE);
    rd(BASE + 16'd1); chk("R4 E8 key byte", rdata, 8'hBE);

    // R9: read and write in one cycle
    wr(BASE, 8'hF0); wr(BASE + 16'd1, 8'h12);
    @(negedge clk); addr = BASE + 16'd1; wdata = 8'h34; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk("R9 read sees old value", rdata, 8'h12);
    rd(BASE + 16'd1); chk("R9 write landed", rdata, 8'h34);

    // R3/R5: sweep of every selector
    for (int s = 0; s < 256; s++) begin
      logic [7:0] pat;
      pat = 8'h5A ^ 8'(s);
      wr(BASE, 8'(s));
      wr(BASE + 16'd1, pat);
      rd(BASE + 16'd1);
      if (m_open(s))
        chk($sformatf("R5 open %02h", s), rdata, pat);
      else if (s == 8'hE7 || s == 8'hE8)
        chk($sformatf("R4 keyed %02h", s), rdata, 8'(m_init(s)));
      else
        chk($sformatf("R3 locked %02h", s), rdata, 8'(m_init(s)));
    end

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 50000);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule